// File: doc/BRIEF.md
# Embedded-Sync Video Capture Writer

This block receives a byte-wide digital video stream whose line and field timing is carried inside the data as reserved code words, rather than on separate sync pins. The stream is sampled on a pixel clock. The block finds each timing preamble and decodes the status byte after it. Every byte of the active part of a line goes into a small dual-clock buffer. On the system-clock side, the bytes are drained into an external asynchronous SRAM at consecutive addresses, in the order they arrived.

A capture input turns acquisition on and off. Each new capture session begins writing at address zero at the first start-of-active-video code. An error output is sticky until reset. It flags malformed status bytes, a full crossing buffer, and samples lost because the address space has run out.

Top module: `vcap_sram_capture`

## Requirements
- R1: A timing code is the byte sequence 0xFF, 0x00, 0x00 followed by one status byte. None of these four bytes is ever written to SRAM.
- R2: The status byte is decoded from bits 6:4 as F, V, H, with bit 7 ignored and bits 3:0 required to be zero. FVH = 000 (0x00 or 0x80) starts active video: every byte after it is written to SRAM, in arrival order, until the next timing code.
- R3: FVH = 010 (0x20) marks a blanking line. No byte after it is written until the next start-of-active code.
- R4: FVH = 111 (0x70 or 0xF0) ends active data. No byte after it is written until the next start-of-active code.
- R5: Each SRAM write drives CE and WE low together for exactly one system-clock cycle. Address and data are stable in the cycle before and the cycle after the strobe. OE stays high at all times.
- R6: The first byte stored in a capture session goes to address 0. Each further stored byte goes to the previous address plus one, across line boundaries.
- R7: While capture is low, no byte is stored. After capture rises, storing begins only at the next start-of-active code, and that session restarts at address 0.
- R8: A status byte with any other value sets the error output. Error stays set until reset. A full crossing buffer also sets it.
- R9: After a write to the top address (all ones), the remaining bytes of that session are dropped, the address stays at the top, and error is set.
- R10: While reset is applied, CE, WE and OE are high and error is low.
- R11: Inside active video, a lone 0xFF, or 0xFF followed by only one 0x00, is ordinary sample data and is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock (SRAM side) |
| pix_clk | input | 1 | Pixel clock for the video stream |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| capture | input | 1 | Acquisition enable |
| vid_in | input | 8 | Video byte stream with embedded timing codes |
| sram_addr | output | ADDR_W (19) | SRAM address |
| sram_data | output | 8 | SRAM write data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low (held high) |
| sram_we_n | output | 1 | SRAM write enable, active low |
| error | output | 1 | Sticky fault flag |

## Verification
Several properties are checked on every cycle: that the write strobe lasts one cycle, that address and data stay stable around it, that a status byte never produces a buffer push, that no push follows a low capture or a blanking code, and that the Gray pointers step by at most one bit. Other behaviours need whole stream scenarios in the bench to show them. These are the address sequence and byte order across lines of many lengths, the restart at address zero after capture toggles, storage of partial preamble lookalikes, saturation at the top address, and the stickiness of the error flag for each cause.

// File: rtl/vcap_pkg.sv
`timescale 1ns/1ps
package vcap_pkg;
  localparam int VID_W = 8;

  localparam logic [VID_W-1:0] PRE_HEAD = 8'hFF;
  localparam logic [VID_W-1:0] PRE_ZERO = 8'h00;

  // F,V,H field values taken from status bits 6:4
  localparam logic [2:0] FVH_ACTIVE = 3'b000;
  localparam logic [2:0] FVH_BLANK  = 3'b010;
  localparam logic [2:0] FVH_END    = 3'b111;

  typedef struct packed {
    logic             first;
    logic [VID_W-1:0] data;
  } vsample_t;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_SETUP,
    WR_STROBE,
    WR_HOLD
  } wr_state_t;
endpackage

// File: rtl/vcap_sync.sv
`timescale 1ns/1ps
module vcap_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/vcap_code_parser.sv
`timescale 1ns/1ps
module vcap_code_parser
  import vcap_pkg::*;
(
  input  logic             pclk,
  input  logic             prst_n,
  input  logic             cap,
  input  logic [VID_W-1:0] vin,
  input  logic             full,
  output logic             push,
  output vsample_t         push_data,
  output logic             err
);
  logic [VID_W-1:0] d0_q, d1_q;
  logic             v0_q, v1_q, v0_n, v1_n;
  logic             exp_q, act_q, act_n, first_q, first_n, err_q, err_n;
  logic             hit, bad;
  logic [2:0]       fvh;
  logic             low_ok;

  assign fvh    = vin[6:4];
  assign low_ok = (vin[3:0] == 4'h0);
  assign hit    = !exp_q && (d1_q == PRE_HEAD) && (d0_q == PRE_ZERO) && (vin == PRE_ZERO);
  assign bad    = exp_q && !(low_ok && (fvh == FVH_ACTIVE || fvh == FVH_BLANK || fvh == FVH_END));

  assign push      = v1_q && !hit;
  assign push_data = '{first: first_q, data: d1_q};
  assign err       = err_q;

  always_comb begin
    v0_n    = act_q && cap && !exp_q && !hit;
    v1_n    = v0_q && cap && !hit;
    act_n   = act_q;
    first_n = first_q;
    err_n   = err_q | bad | (push && full);
    if (exp_q) begin
      act_n = cap && low_ok && (fvh == FVH_ACTIVE);
    end
    if (!cap) begin
      act_n   = 1'b0;
      first_n = 1'b1;
    end else if (push && !full) begin
      first_n = 1'b0;
    end
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      d0_q    <= '0;
      d1_q    <= '0;
      v0_q    <= 1'b0;
      v1_q    <= 1'b0;
      exp_q   <= 1'b0;
      act_q   <= 1'b0;
      first_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      d0_q    <= vin;
      d1_q    <= d0_q;
      v0_q    <= v0_n;
      v1_q    <= v1_n;
      exp_q   <= hit;
      act_q   <= act_n;
      first_q <= first_n;
      err_q   <= err_n;
    end
  end

  // R1: the status byte cycle never yields a push
  a_r1_no_push_on_status: assert property (@(posedge pclk) disable iff (!prst_n)
    exp_q |-> !push);
  // R7: capture low means the following cycle pushes nothing
  a_r7_cap_low_quiet: assert property (@(posedge pclk) disable iff (!prst_n)
    !cap |=> !push);
  // R3: a blanking code is followed by no push
  a_r3_blank_quiet: assert property (@(posedge pclk) disable iff (!prst_n)
    (exp_q && fvh == FVH_BLANK) |=> !push);
endmodule

// File: rtl/vcap_cdc_fifo.sv
`timescale 1ns/1ps
module vcap_cdc_fifo #(
  parameter int DW = 9,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin_q, wbin_n, wgray_q, wgray_n, rgray_w;
  logic [PW-1:0] rbin_q, rbin_n, rgray_q, rgray_n, wgray_r;
  logic          wr_ok, rd_ok;

  vcap_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_w));
  vcap_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_r));

  assign full  = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign empty = (rgray_q == wgray_r);
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;
  assign rdata = mem[rbin_q[AW-1:0]];

  always_comb begin
    wbin_n  = wbin_q + PW'(wr_ok);
    wgray_n = wbin_n ^ (wbin_n >> 1);
    rbin_n  = rbin_q + PW'(rd_ok);
    rgray_n = rbin_n ^ (rbin_n >> 1);
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wgray_n;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= rgray_n;
    end
  end

  a_fifo_wgray_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  a_fifo_rgray_step: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/vcap_sram_writer.sv
`timescale 1ns/1ps
module vcap_sram_writer
  import vcap_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              empty,
  input  vsample_t          rd,
  output logic              pop,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [VID_W-1:0]  sram_data,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              err
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}};

  wr_state_t         st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n, nxt_q, nxt_n, wa;
  logic [VID_W-1:0]  data_q, data_n;
  logic              top_q, top_n, err_q, err_n, stb_n_q;
  logic              take, blocked;

  assign take    = ((st_q == WR_IDLE) || (st_q == WR_HOLD)) && !empty;
  assign pop     = take;
  assign wa      = rd.first ? '0 : nxt_q;
  assign blocked = !rd.first && top_q;

  always_comb begin
    st_n   = st_q;
    addr_n = addr_q;
    data_n = data_q;
    nxt_n  = nxt_q;
    top_n  = top_q;
    err_n  = err_q;
    if (take) begin
      if (blocked) begin
        err_n = 1'b1;
        st_n  = WR_IDLE;
      end else begin
        addr_n = wa;
        data_n = rd.data;
        nxt_n  = (wa == ADDR_MAX) ? wa : wa + 1'b1;
        top_n  = (wa == ADDR_MAX);
        st_n   = WR_SETUP;
      end
    end else begin
      case (st_q)
        WR_SETUP:  st_n = WR_STROBE;
        WR_STROBE: st_n = WR_HOLD;
        WR_HOLD:   st_n = WR_IDLE;
        default:   st_n = WR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WR_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      nxt_q   <= '0;
      top_q   <= 1'b0;
      err_q   <= 1'b0;
      stb_n_q <= 1'b1;
    end else begin
      st_q    <= st_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      nxt_q   <= nxt_n;
      top_q   <= top_n;
      err_q   <= err_n;
      stb_n_q <= (st_n != WR_STROBE);
    end
  end

  assign sram_addr = addr_q;
  assign sram_data = data_q;
  assign sram_ce_n = stb_n_q;
  assign sram_we_n = stb_n_q;
  assign sram_oe_n = 1'b1;
  assign err       = err_q;

  // R5: strobe lasts a single cycle
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n);
  // R5: address and data set up one cycle before the strobe
  a_r5_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_data)));
  // R5: address and data held one cycle after the strobe
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_data)));
endmodule

// File: rtl/vcap_sram_capture.sv
`timescale 1ns/1ps
module vcap_sram_capture
  import vcap_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int FIFO_AW = 5
) (
  input  logic              sys_clk,
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [7:0]        vid_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [7:0]        sram_data,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              error
);
  localparam int SW = $bits(vsample_t);

  logic     sys_rst_n, pix_rst_n, cap_p;
  logic     push, full, pop, empty;
  vsample_t push_data, rd_sample;
  logic [SW-1:0] rd_bits;
  logic     err_pix, err_pix_s, err_wr, err_q;

  vcap_sync #(.W(1)) u_srst (.clk(sys_clk), .rst_n(rst_n), .d(1'b1), .q(sys_rst_n));
  vcap_sync #(.W(1)) u_prst (.clk(pix_clk), .rst_n(rst_n), .d(1'b1), .q(pix_rst_n));
  vcap_sync #(.W(1)) u_cap  (.clk(pix_clk), .rst_n(pix_rst_n), .d(capture), .q(cap_p));

  vcap_code_parser u_parse (
    .pclk(pix_clk), .prst_n(pix_rst_n), .cap(cap_p), .vin(vid_in),
    .full(full), .push(push), .push_data(push_data), .err(err_pix)
  );

  vcap_cdc_fifo #(.DW(SW), .AW(FIFO_AW)) u_fifo (
    .wclk(pix_clk), .wrst_n(pix_rst_n), .wr_en(push), .wdata(push_data), .full(full),
    .rclk(sys_clk), .rrst_n(sys_rst_n), .rd_en(pop), .rdata(rd_bits), .empty(empty)
  );

  assign rd_sample = vsample_t'(rd_bits);

  vcap_sram_writer #(.ADDR_W(ADDR_W)) u_wr (
    .clk(sys_clk), .rst_n(sys_rst_n), .empty(empty), .rd(rd_sample), .pop(pop),
    .sram_addr(sram_addr), .sram_data(sram_data), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .err(err_wr)
  );

  vcap_sync #(.W(1)) u_err (.clk(sys_clk), .rst_n(sys_rst_n), .d(err_pix), .q(err_pix_s));

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) err_q <= 1'b0;
    else            err_q <= err_q | err_pix_s | err_wr;
  end

  assign error = err_q;

  // R8: error never clears without reset
  a_r8_error_sticky: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    error |=> error);
endmodule

// File: tb/sim_vcap_sram_capture.sv
`timescale 1ns/1ps
module sim_vcap_sram_capture;
  localparam int AW   = 6;
  localparam int TOP  = (1 << AW) - 1;
  localparam int LOGN = 512;

  logic          sys_clk = 1'b0, pix_clk = 1'b0;
  logic          rst_n, capture;
  logic [7:0]    vid;
  logic [AW-1:0] sram_addr;
  logic [7:0]    sram_data;
  logic          sram_ce_n, sram_oe_n, sram_we_n, error;

  always #10 sys_clk = ~sys_clk;
  always #20 pix_clk = ~pix_clk;

  vcap_sram_capture #(.ADDR_W(AW), .FIFO_AW(5)) u0 (
    .sys_clk(sys_clk), .pix_clk(pix_clk), .rst_n(rst_n), .capture(capture),
    .vid_in(vid), .sram_addr(sram_addr), .sram_data(sram_data),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .error(error)
  );

  int n_chk = 0, n_fail = 0;
  int log_n = 0, viol = 0;
  logic [AW-1:0] log_a [LOGN];
  logic [7:0]    log_d [LOGN];
  int exp_n = 0, cmp_i = 0;
  logic [AW-1:0] exp_a [LOGN];
  logic [7:0]    exp_d [LOGN];
  int  e_addr = 0;
  bit  e_full = 0;

  // write monitor, sampled away from the active edge
  always @(negedge sys_clk) begin
    if (rst_n === 1'b1) begin
      if (sram_oe_n !== 1'b1 || sram_ce_n !== sram_we_n) viol <= viol + 1;
      if (sram_we_n === 1'b0 && log_n < LOGN) begin
        log_a[log_n] <= sram_addr;
        log_d[log_n] <= sram_data;
        log_n <= log_n + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic px(input logic [7:0] b);
    @(negedge pix_clk);
    vid = b;
  endtask

  task automatic code(input logic [7:0] s);
    px(8'hFF); px(8'h00); px(8'h00); px(s);
  endtask

  task automatic filler(input int n);
    for (int i = 0; i < n; i++) px(8'h10 + 8'(i));
  endtask

  task automatic new_session();
    e_addr = 0;
    e_full = 0;
  endtask

  task automatic sample(input logic [7:0] b);
    px(b);
    if (!e_full) begin
      exp_a[exp_n] = AW'(e_addr);
      exp_d[exp_n] = b;
      exp_n++;
      if (e_addr == TOP) e_full = 1;
      else e_addr++;
    end
  endtask

  function automatic logic [7:0] val(input int line, input int i);
    return 8'(((line * 37 + i * 11) % 254) + 1);
  endfunction

  task automatic drain();
    repeat (300) @(negedge sys_clk);
  endtask

  task automatic compare(input string req);
    for (int i = cmp_i; i < exp_n; i++) begin
      chk({req, " R6 address"}, int'(log_a[i]), int'(exp_a[i]));
      chk({req, " R2 data"}, int'(log_d[i]), int'(exp_d[i]));
    end
    chk({req, " write count"}, log_n, exp_n);
    cmp_i = exp_n;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge sys_clk);
    chk("R10 we_n in reset", int'(sram_we_n), 1);
    chk("R10 ce_n in reset", int'(sram_ce_n), 1);
    chk("R10 oe_n in reset", int'(sram_oe_n), 1);
    chk("R10 error in reset", int'(error), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge sys_clk);
    new_session();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    capture = 1'b0;
    vid     = 8'h00;
    do_reset();

    // R1 R2 R3 R4 R11: lines of lengths 1..8 in one session
    capture = 1'b1;
    filler(6);
    code(8'h20);
    filler(5);
    for (int line = 1; line <= 8; line++) begin
      code((line % 2 == 0) ? 8'h80 : 8'h00);
      for (int i = 0; i < line; i++) sample(val(line, i));
      code((line % 2 == 0) ? 8'hF0 : 8'h70);
      filler(3);
      code(8'h20);
      filler(4);
    end
    // R11: partial preamble lookalikes are data
    code(8'h00);
    sample(8'hFF); sample(8'h11);
    sample(8'hFF); sample(8'h00); sample(8'h22);
    sample(8'h00); sample(8'h00); sample(8'h33);
    code(8'h70);
    filler(4);
    drain();
    compare("R1 R3 R4 R11 sweep");
    chk("R8 no error on valid codes", int'(error), 0);

    // R7: capture low stores nothing, even across a start code
    capture = 1'b0;
    filler(8);
    code(8'h00);
    filler(5);
    code(8'h70);
    code(8'h00);
    filler(2);
    capture = 1'b1;
    filler(8);
    code(8'h70);
    drain();
    chk("R7 nothing stored while idle", log_n, exp_n);
    new_session();
    code(8'h00);
    for (int i = 0; i < 10; i++) sample(val(20, i));
    code(8'h70);
    drain();
    compare("R7 restart at zero");

    // R9: saturation at top address
    capture = 1'b0;
    filler(6);
    capture = 1'b1;
    filler(6);
    new_session();
    code(8'h00);
    for (int i = 0; i < 70; i++) sample(val(30, i));
    code(8'h70);
    drain();
    compare("R9 saturate");
    chk("R9 error after saturation", int'(error), 1);

    // R8: invalid F,V,H combination
    do_reset();
    code(8'h35);
    filler(4);
    drain();
    chk("R8 error on bad fvh", int'(error), 1);
    code(8'h00);
    for (int i = 0; i < 6; i++) sample(val(40, i));
    code(8'h70);
    drain();
    compare("R8 traffic after error");
    chk("R8 error stays set", int'(error), 1);

    // R8: nonzero low status bits
    do_reset();
    code(8'h24);
    filler(4);
    drain();
    chk("R8 error on low bits", int'(error), 1);

    chk("R5 oe high and ce follows we", viol, 0);
    summary();
    $finish;
  end
endmodule